// File: doc/BRIEF.md
# Page Translation Map with Two-Level Valid State

This block holds the translation entries of a paged memory system. It has 1024 entries, addressed by an exec/user mode bit and a 9-bit virtual page number. Each entry holds a 12-bit real page number, three permission bits (read, write, execute) and its own valid flag. On top of that, a second valid flag covers each aligned group of four entries. A lookup names a page and the kind of cycle it is for. One clock later the block returns the real page, a miss flag, and a fault flag when the stored permissions refuse that kind of cycle.

A refill engine outside the block uses one maintenance port to change the map. A group write fills all four entries of a group in one operation and marks only the good ones valid. A single write fills one entry. A single invalidate drops one entry. A bulk invalidate drops the group flags of 256 pages at once, so either half of the map (exec or user) empties in two operations. Internally the storage is four quarter banks, selected by the two lowest page bits, so a group write touches one row in every bank.

Top module: `page_map`

## Requirements
- R1: After reset every lookup reports a miss, and `lk_valid` stays low until a lookup is requested.
- R2: A lookup requested in cycle n is answered in cycle n+1 with `lk_valid` high. In a cycle with no answer, `lk_miss`, `lk_fault` and `lk_rpa` are all zero.
- R3: Each pair of mode bit and 9-bit page number selects its own entry, so writing one entry never changes what another entry returns.
- R4: A lookup misses when the group flag of its group ({mode, page[8:2]}) is clear or its entry flag is clear. A miss returns `lk_rpa` = 0 and `lk_fault` = 0.
- R5: On a hit, `lk_cyc` 2'b00 (read) needs permission bit 2, 2'b01 (write or store check) needs bit 1, and 2'b10 (execute) needs bit 0. `lk_fault` rises when the needed bit is 0, and `lk_cyc` 2'b11 always faults on a hit. `lk_rpa` returns the stored page even when the lookup faults.
- R6: An entry written with permission bits 3'b000 is valid (no miss), and every cycle type on it faults.
- R7: Group write (op 2) fills the four entries {mode, page[8:2], i} for i = 0..3. Entry i takes real page `mnt_rpa[12i+11:12i]` and permissions `mnt_acc[3i+2:3i]`, and is marked valid only if `mnt_good[i]` is 1. The group flag is set.
- R8: Single write (op 1) stores `mnt_rpa[11:0]` and `mnt_acc[2:0]` in entry {mode, page} and marks it valid. If that entry's group flag was clear, the other three entries of the group become invalid and the group flag is set. If the flag was already set, the other three keep their contents.
- R9: Single invalidate (op 3) makes only entry {mode, page} miss. The other entries of its group are unchanged.
- R10: Bulk invalidate (op 4) clears the group flags of all 256 pages whose mode equals `mnt_mode` and whose page bit 8 equals `mnt_vpn[8]`. All other pages are untouched.
- R11: When a maintenance operation and a lookup hit the same entry in the same cycle, the lookup reports the contents after the operation.
- R12: `mnt_op` codes 0 and 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_mode | input | 1 | Lookup space: 0 exec, 1 user |
| lk_vpn | input | 9 | Lookup virtual page number |
| lk_cyc | input | 2 | Cycle type: 00 read, 01 write/store check, 10 execute |
| lk_valid | output | 1 | Lookup answer present this cycle |
| lk_rpa | output | 12 | Real page number (zero on a miss) |
| lk_miss | output | 1 | Entry or its group is not valid |
| lk_fault | output | 1 | Entry valid but the cycle type is not permitted |
| mnt_op | input | 3 | 0 none, 1 single write, 2 group write, 3 entry invalidate, 4 half-bank invalidate |
| mnt_mode | input | 1 | Maintenance target space |
| mnt_vpn | input | 9 | Maintenance target page |
| mnt_rpa | input | 48 | Four real page numbers, lane i at bits 12i+11:12i |
| mnt_acc | input | 12 | Four permission triples, lane i at bits 3i+2:3i as {r,w,x} |
| mnt_good | input | 4 | Per-lane valid for a group write |

## Verification
A wrong group flag shows up in the very next lookup of any of the four pages that share it. All four miss together, or all four return stale pages together, so a group fault appears as a pattern of four neighbours, while a wrong entry flag affects one page only. A bad bulk invalidate shows as a band of 256 pages. Those pages either still hit or miss when they should not, and only the full sweep after each clear covers every band. Permission errors show on the same lookup as a fault flag that disagrees with one stored bit. Because every answer comes exactly one cycle after its request, a stale or bypassed state is seen at once and is never hidden behind a delay.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [2:0] {
    PM_OP_NONE     = 3'd0,
    PM_OP_WR_ONE   = 3'd1,
    PM_OP_WR_GROUP = 3'd2,
    PM_OP_INV_ONE  = 3'd3,
    PM_OP_INV_HALF = 3'd4
  } pm_op_e;

  localparam int PM_ACC_W = 3;

  // permission triple is {read, write, execute}
  function automatic logic pm_perm_ok(input logic [PM_ACC_W-1:0] acc,
                                      input logic [1:0] cyc);
    logic ok;
    case (cyc)
      2'b00:   ok = acc[2];
      2'b01:   ok = acc[1];
      2'b10:   ok = acc[0];
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pm_qbank.sv
module pm_qbank #(
  parameter int AW = 8,
  parameter int DW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic          valid_we,
  input  logic [AW-1:0] w_idx,
  input  logic [DW-1:0] w_rpa,
  input  logic [PW-1:0] w_acc,
  input  logic          w_v,
  input  logic [AW-1:0] r_idx,
  output logic [DW-1:0] r_rpa,
  output logic [PW-1:0] r_acc,
  output logic          r_v
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    rpa_mem [DEPTH];
  logic [PW-1:0]    acc_mem [DEPTH];
  logic [DEPTH-1:0] v_mem;

  always_ff @(posedge clk) begin
    if (data_we) begin
      rpa_mem[w_idx] <= w_rpa;
      acc_mem[w_idx] <= w_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        v_mem        <= '0;
    else if (valid_we) v_mem[w_idx] <= w_v;
  end

  assign r_rpa = rpa_mem[r_idx];
  assign r_acc = acc_mem[r_idx];
  assign r_v   = v_mem[r_idx];
endmodule

// File: rtl/pm_grpvalid.sv
module pm_grpvalid #(
  parameter int AW = 8,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic          bulk_en,
  input  logic [BW-1:0] bulk_sel,
  input  logic [AW-1:0] r_idx,
  output logic          r_bit,
  input  logic [AW-1:0] q_idx,
  output logic          q_bit
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] gv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv <= '0;
    end else if (bulk_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i[AW-1 -: BW] == bulk_sel) gv[i] <= 1'b0;
      end
    end else if (set_en) begin
      gv[set_idx] <= 1'b1;
    end
  end

  assign r_bit = gv[r_idx];
  assign q_bit = gv[q_idx];
endmodule

// File: rtl/page_map.sv
module page_map #(
  parameter int VPN_W = 9,
  parameter int RPA_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_en,
  input  logic                 lk_mode,
  input  logic [VPN_W-1:0]     lk_vpn,
  input  logic [1:0]           lk_cyc,
  output logic                 lk_valid,
  output logic [RPA_W-1:0]     lk_rpa,
  output logic                 lk_miss,
  output logic                 lk_fault,
  input  logic [2:0]           mnt_op,
  input  logic                 mnt_mode,
  input  logic [VPN_W-1:0]     mnt_vpn,
  input  logic [4*RPA_W-1:0]   mnt_rpa,
  input  logic [4*3-1:0]       mnt_acc,
  input  logic [3:0]           mnt_good
);
  import pm_pkg::*;

  localparam int LANES  = 4;
  localparam int QS_W   = 2;
  localparam int ACC_W  = PM_ACC_W;
  localparam int GAW    = 1 + VPN_W - QS_W;
  localparam int BULK_W = 2;

  // ---- maintenance decode (named for the checker) ----
  logic op_wr_one, op_wr_grp, op_inv_one, op_inv_half;
  assign op_wr_one   = (mnt_op == PM_OP_WR_ONE);
  assign op_wr_grp   = (mnt_op == PM_OP_WR_GROUP);
  assign op_inv_one  = (mnt_op == PM_OP_INV_ONE);
  assign op_inv_half = (mnt_op == PM_OP_INV_HALF);

  logic [GAW-1:0]  w_grp;
  logic [QS_W-1:0] w_q;
  logic            grp_was_valid;
  assign w_grp = {mnt_mode, mnt_vpn[VPN_W-1:QS_W]};
  assign w_q   = mnt_vpn[QS_W-1:0];

  // ---- registered lookup request ----
  logic             req_v, req_mode;
  logic [VPN_W-1:0] req_vpn;
  logic [1:0]       req_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v    <= 1'b0;
      req_mode <= 1'b0;
      req_vpn  <= '0;
      req_cyc  <= '0;
    end else begin
      req_v <= lk_en;
      if (lk_en) begin
        req_mode <= lk_mode;
        req_vpn  <= lk_vpn;
        req_cyc  <= lk_cyc;
      end
    end
  end

  logic [GAW-1:0]  r_grp;
  logic [QS_W-1:0] r_q;
  assign r_grp = {req_mode, req_vpn[VPN_W-1:QS_W]};
  assign r_q   = req_vpn[QS_W-1:0];

  // ---- group flags ----
  logic grp_hit;
  pm_grpvalid #(.AW(GAW), .BW(BULK_W)) u_grp (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (op_wr_one | op_wr_grp),
    .set_idx  (w_grp),
    .bulk_en  (op_inv_half),
    .bulk_sel ({mnt_mode, mnt_vpn[VPN_W-1]}),
    .r_idx    (r_grp),
    .r_bit    (grp_hit),
    .q_idx    (w_grp),
    .q_bit    (grp_was_valid)
  );

  // ---- quarter banks ----
  logic [RPA_W-1:0] bk_rpa [LANES];
  logic [ACC_W-1:0] bk_acc [LANES];
  logic [LANES-1:0] bk_v;

  for (genvar q = 0; q < LANES; q++) begin : g_bank
    logic own, d_we, v_we, v_new;
    logic [RPA_W-1:0] wr_rpa;
    logic [ACC_W-1:0] wr_acc;
    assign own   = (w_q == q[QS_W-1:0]);
    assign d_we  = op_wr_grp | (op_wr_one & own);
    assign v_we  = op_wr_grp | (op_inv_one & own) |
                   (op_wr_one & (own | !grp_was_valid));
    assign v_new = op_wr_grp ? mnt_good[q] : (op_wr_one & own);
    assign wr_rpa = op_wr_grp ? mnt_rpa[q*RPA_W +: RPA_W] : mnt_rpa[RPA_W-1:0];
    assign wr_acc = op_wr_grp ? mnt_acc[q*ACC_W +: ACC_W] : mnt_acc[ACC_W-1:0];

    pm_qbank #(.AW(GAW), .DW(RPA_W), .PW(ACC_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_we  (d_we),
      .valid_we (v_we),
      .w_idx    (w_grp),
      .w_rpa    (wr_rpa),
      .w_acc    (wr_acc),
      .w_v      (v_new),
      .r_idx    (r_grp),
      .r_rpa    (bk_rpa[q]),
      .r_acc    (bk_acc[q]),
      .r_v      (bk_v[q])
    );
  end

  // ---- answer ----
  logic             ent_hit, hit, perm_ok;
  logic [RPA_W-1:0] sel_rpa;
  logic [ACC_W-1:0] sel_acc;
  assign ent_hit = bk_v[r_q];
  assign sel_rpa = bk_rpa[r_q];
  assign sel_acc = bk_acc[r_q];
  assign hit     = req_v & grp_hit & ent_hit;
  assign perm_ok = pm_perm_ok(sel_acc, req_cyc);

  assign lk_valid = req_v;
  assign lk_miss  = req_v & !(grp_hit & ent_hit);
  assign lk_fault = hit & !perm_ok;
  assign lk_rpa   = hit ? sel_rpa : '0;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int VPN_W = 9,
  parameter int RPA_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_en,
  input logic               lk_mode,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_valid,
  input logic [RPA_W-1:0]   lk_rpa,
  input logic               lk_miss,
  input logic               lk_fault,
  input logic               op_wr_grp,
  input logic               op_inv_one,
  input logic               op_inv_half,
  input logic               mnt_mode,
  input logic [VPN_W-1:0]   mnt_vpn,
  input logic [4*RPA_W-1:0] mnt_rpa,
  input logic [3:0]         mnt_good
);
  logic [RPA_W-1:0] lane_rpa;
  logic             lane_good, same_grp, same_ent, same_half;
  assign lane_rpa  = mnt_rpa[lk_vpn[1:0]*RPA_W +: RPA_W];
  assign lane_good = mnt_good[lk_vpn[1:0]];
  assign same_grp  = lk_en && lk_mode == mnt_mode && lk_vpn[VPN_W-1:2] == mnt_vpn[VPN_W-1:2];
  assign same_ent  = lk_en && lk_mode == mnt_mode && lk_vpn == mnt_vpn;
  assign same_half = lk_en && lk_mode == mnt_mode && lk_vpn[VPN_W-1] == mnt_vpn[VPN_W-1];

  p_answer_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> lk_valid);
  p_no_answer_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_miss && !lk_fault && lk_rpa == '0));
  p_miss_excludes_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (!lk_fault && lk_rpa == '0));
  p_group_write_seen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_grp && same_grp && lane_good) |=> (!lk_miss && lk_rpa == $past(lane_rpa)));
  p_entry_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_inv_one && same_ent) |=> lk_miss);
  p_half_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_inv_half && same_half) |=> lk_miss);
endmodule

bind page_map pm_checker #(.VPN_W(VPN_W), .RPA_W(RPA_W)) u_pm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_en       (lk_en),
  .lk_mode     (lk_mode),
  .lk_vpn      (lk_vpn),
  .lk_valid    (lk_valid),
  .lk_rpa      (lk_rpa),
  .lk_miss     (lk_miss),
  .lk_fault    (lk_fault),
  .op_wr_grp   (op_wr_grp),
  .op_inv_one  (op_inv_one),
  .op_inv_half (op_inv_half),
  .mnt_mode    (mnt_mode),
  .mnt_vpn     (mnt_vpn),
  .mnt_rpa     (mnt_rpa),
  .mnt_good    (mnt_good)
);

// File: tb/tb_page_map.sv
`timescale 1ns/1ps
module tb_page_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0, lk_mode = 1'b0;
  logic [8:0]  lk_vpn = '0;
  logic [1:0]  lk_cyc = '0;
  logic        lk_valid, lk_miss, lk_fault;
  logic [11:0] lk_rpa;
  logic [2:0]  mnt_op = '0;
  logic        mnt_mode = 1'b0;
  logic [8:0]  mnt_vpn = '0;
  logic [47:0] mnt_rpa = '0;
  logic [11:0] mnt_acc = '0;
  logic [3:0]  mnt_good = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // model of the required state
  bit         m_gv  [256];
  bit         m_ev  [1024];
  logic [11:0] m_rpa [1024];
  logic [2:0]  m_acc [1024];

  always #5 clk = ~clk;

  page_map dut (.*);

  function automatic logic [11:0] pat_rpa(int i);
    return 12'((i * 37 + 90) % 4096);
  endfunction
  function automatic logic [2:0] pat_acc(int i);
    return 3'((i * 5 + 1) % 8);
  endfunction

  task automatic model_op(input logic [2:0] op, input logic md, input logic [8:0] vp,
                          input logic [47:0] rp, input logic [11:0] ac, input logic [3:0] gd);
    int g, e;
    g = md * 128 + vp / 4;
    e = md * 512 + vp;
    case (op)
      3'd1: begin
        if (!m_gv[g]) for (int k = 0; k < 4; k++) m_ev[g*4+k] = 1'b0;
        m_gv[g] = 1'b1;
        m_ev[e] = 1'b1; m_rpa[e] = rp[11:0]; m_acc[e] = ac[2:0];
      end
      3'd2: begin
        for (int k = 0; k < 4; k++) begin
          m_rpa[g*4+k] = rp[k*12 +: 12];
          m_acc[g*4+k] = ac[k*3 +: 3];
          m_ev[g*4+k]  = gd[k];
        end
        m_gv[g] = 1'b1;
      end
      3'd3: m_ev[e] = 1'b0;
      3'd4: for (int k = 0; k < 64; k++) m_gv[md*128 + vp[8]*64 + k] = 1'b0;
      default: ;
    endcase
  endtask

  // drive one cycle at a falling edge, wait for the next falling edge
  task automatic step(input logic [2:0] op, input logic md, input logic [8:0] vp,
                      input logic [47:0] rp, input logic [11:0] ac, input logic [3:0] gd,
                      input logic le, input logic lm, input logic [8:0] lv, input logic [1:0] lc);
    mnt_op = op; mnt_mode = md; mnt_vpn = vp; mnt_rpa = rp; mnt_acc = ac; mnt_good = gd;
    lk_en = le; lk_mode = lm; lk_vpn = lv; lk_cyc = lc;
    model_op(op, md, vp, rp, ac, gd);
    @(negedge clk);
    mnt_op = 3'd0; lk_en = 1'b0;
  endtask

  task automatic check_ans(input string tag, input bit ev, input logic md,
                           input logic [8:0] vp, input logic [1:0] cy);
    int e;
    bit hit, perm;
    logic [11:0] x_rpa;
    bit x_miss, x_fault;
    e = md * 512 + vp;
    hit = ev && m_gv[e / 4] && m_ev[e];
    perm = (cy != 2'b11) && m_acc[e][2 - cy];
    x_miss = ev && !hit;
    x_fault = hit && !perm;
    x_rpa = hit ? m_rpa[e] : 12'h000;
    n_checks++;
    if (lk_valid !== ev || lk_miss !== x_miss || lk_fault !== x_fault || lk_rpa !== x_rpa) begin
      n_fail++;
      $display("FAIL %s page=%0d.%03h cyc=%0d got v=%0b m=%0b f=%0b rpa=%03h exp v=%0b m=%0b f=%0b rpa=%03h",
               tag, md, vp, cy, lk_valid, lk_miss, lk_fault, lk_rpa, ev, x_miss, x_fault, x_rpa);
    end
  endtask

  task automatic look(input string tag, input logic md, input logic [8:0] vp, input logic [1:0] cy);
    step(3'd0, 1'b0, 9'd0, 48'd0, 12'd0, 4'd0, 1'b1, md, vp, cy);
    check_ans(tag, 1'b1, md, vp, cy);
  endtask

  task automatic sweep(input string tag, input int rot);
    for (int i = 0; i < 1024; i++) look(tag, i[9], i[8:0], 2'((i + rot) % 4));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [47:0] rp;
    logic [11:0] ac;
    logic [3:0]  gd;
    for (int i = 0; i < 256; i++) m_gv[i] = 1'b0;
    for (int i = 0; i < 1024; i++) begin m_ev[i] = 1'b0; m_rpa[i] = '0; m_acc[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset state and idle cycle
    check_ans("R1 reset idle", 1'b0, 1'b0, 9'd0, 2'd0);
    look("R1 after reset", 1'b0, 9'h000, 2'd0);
    look("R1 after reset", 1'b1, 9'h1FF, 2'd2);
    step(3'd0, 1'b0, 9'd0, 48'd0, 12'd0, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    check_ans("R2 no request", 1'b0, 1'b0, 9'd0, 2'd0);

    // R7: fill every group, some lanes not good
    for (int g = 0; g < 256; g++) begin
      for (int k = 0; k < 4; k++) begin
        rp[k*12 +: 12] = pat_rpa(g*4 + k);
        ac[k*3 +: 3]   = pat_acc(g*4 + k);
      end
      gd = (g % 7 == 3) ? (4'(g) ^ 4'h5) : 4'hF;
      step(3'd2, g[7], 9'({g[6:0], 2'b00}), rp, ac, gd, 1'b0, 1'b0, 9'd0, 2'd0);
    end
    // R3 R4 R5 R7: full sweeps with rotating cycle types
    sweep("R7 group fill R5 perms R3 distinct", 0);
    sweep("R7 group fill R5 perms R3 distinct", 1);
    sweep("R4 R5 sweep", 3);

    // R10: clear exec low half, then exec high half
    step(3'd4, 1'b0, 9'h000, 48'd0, 12'd0, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    sweep("R10 first half clear", 2);
    step(3'd4, 1'b0, 9'h100, 48'd0, 12'd0, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    sweep("R10 second half clear", 0);

    // R8: single write into a cleared group, then into a live group
    step(3'd1, 1'b0, 9'h011, 48'h000_000_000_ABC, 12'o7, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    for (int k = 0; k < 4; k++) look("R8 cleared group", 1'b0, 9'(16 + k), 2'd0);
    step(3'd1, 1'b1, 9'h025, 48'h000_000_000_5D3, 12'o6, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    for (int k = 0; k < 4; k++) look("R8 live group", 1'b1, 9'(36 + k), 2'd1);

    // R9: single invalidate
    step(3'd3, 1'b1, 9'h031, 48'd0, 12'd0, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    for (int k = 0; k < 4; k++) look("R9 entry drop", 1'b1, 9'(48 + k), 2'd0);

    // R6: zero permissions
    step(3'd1, 1'b1, 9'h100, 48'h000_000_000_777, 12'o0, 4'd0, 1'b0, 1'b0, 9'd0, 2'd0);
    for (int c = 0; c < 4; c++) look("R6 zero perms", 1'b1, 9'h100, 2'(c));

    // R11: same-cycle write / invalidate with lookup
    step(3'd1, 1'b1, 9'h101, 48'h000_000_000_E21, 12'o4, 4'd0, 1'b1, 1'b1, 9'h101, 2'd0);
    check_ans("R11 write bypass", 1'b1, 1'b1, 9'h101, 2'd0);
    step(3'd3, 1'b1, 9'h102, 48'd0, 12'd0, 4'd0, 1'b1, 1'b1, 9'h102, 2'd0);
    check_ans("R11 invalidate bypass", 1'b1, 1'b1, 9'h102, 2'd0);
    step(3'd2, 1'b1, 9'h104, 48'h123_456_789_ABC, 12'o1234, 4'hB, 1'b1, 1'b1, 9'h105, 2'd2);
    check_ans("R11 group bypass", 1'b1, 1'b1, 9'h105, 2'd2);

    // R12: reserved op codes do nothing
    for (int op = 5; op < 8; op++) begin
      step(3'(op), 1'b1, 9'h103, 48'hFFF_FFF_FFF_FFF, 12'o0, 4'h0, 1'b1, 1'b1, 9'h103, 2'd0);
      check_ans("R12 reserved op", 1'b1, 1'b1, 9'h103, 2'd0);
      step(3'(op), 1'b1, 9'h0C0, 48'd0, 12'd0, 4'h0, 1'b0, 1'b0, 9'd0, 2'd0);
      look("R12 reserved op half", 1'b1, 9'h0C1, 2'd1);
    end
    step(3'd0, 1'b1, 9'h040, 48'hFFF_FFF_FFF_FFF, 12'o7777, 4'hF, 1'b0, 1'b0, 9'd0, 2'd0);
    look("R12 op none", 1'b1, 9'h040, 2'd0);

    finish_run();
  end
endmodule